// File: doc/BRIEF.md
# Mixed Static/Dynamic Bus Cycle Controller

This block decides, unit by unit, when one node may drive a shared broadcast bus. Bus time is counted in units, and one clock equals one unit. The bus repeats a cycle of fixed length. A table of up to eight entries splits the cycle into phases. Each entry gives the phase kind (static or dynamic), its length in units, and, for a static entry, the node that owns that slot. Consecutive static entries together form one static phase made of several slots.

In a slot owned by this node, a ready static frame is launched on the slot's first unit, which serves as a guard unit. The frame then fills the rest of the slot. In a dynamic phase, the highest-priority message from a local queue of eight entries is offered to arbitration. It is offered only if the frame can end before the phase does. Arbitration is a priority compare against the strongest request from the other nodes. A frame that has won the bus runs to completion. Strobes mark the first and the last unit of every frame.

The controller is a three-state machine:
- `S_IDLE` waits for an opportunity.
- `S_TX_ST` carries a static frame.
- `S_TX_DYN` carries a dynamic frame.

Its transitions are:
- static launch: `S_IDLE`→`S_TX_ST`.
- dynamic grant: `S_IDLE`→`S_TX_DYN`.
- frame end: either transmit state back to `S_IDLE`, taken on the unit that raises `tx_done`.

Top module: `mixbus_ctrl`

## Requirements
- R1: `cyc_pos` counts 0 to CYC_LEN-1, one step per clock, and wraps to 0. Reset sets it to 0.
- R2: Table entries are taken in index order starting at unit 0 of every cycle. Entry i is dynamic when `cfg_dyn[i]`=1. Its length is `cfg_len[i*LEN_W +: LEN_W]` and its owner is `cfg_own[i*NODE_W +: NODE_W]`. The first zero-length entry, or the end of the table, leaves the rest of the cycle idle, and nothing is launched there.
- R3: Static launch happens on the first unit of a static slot of length L≥2 when the slot is owned by NODE_ID and `st_ready`=1. In that case `tx_start` rises on the next unit with `tx_dyn`=0. The frame lasts L-1 units and `tx_done` marks the slot's last unit.
- R4: A slot owned by another node, or a slot whose first unit sees `st_ready`=0, carries no transmission from this node.
- R5: A push with nonzero `dq_len` enters the queue (capacity QDEPTH). Priorities are unique, and a larger `dq_prio` value means higher priority. The queued message with the highest priority is offered first, whatever the push order. During an offer, `bus_req`=1 and `req_prio` shows that priority.
- R6: An offer is made in a dynamic phase when the bus is idle and the frame length F is strictly below the units left in the phase, counting the current unit. If the offer is granted, the frame occupies the next F units. A message that does not fit waits for a later dynamic phase, possibly in a later cycle.
- R7: An offer wins when `peer_req`=0 or when `req_prio` > `peer_prio`. A lost offer starts nothing on the next unit and keeps the message queued. While `bus_busy`=1, no offer is made.
- R8: A frame is never preempted. `tx_active` stays high over consecutive units from `tx_start` to `tx_done`, and it drops on the unit after `tx_done`.
- R9: Reset empties the queue and leaves `tx_active`, `tx_start`, `tx_done` and `bus_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus time unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dyn | input | NPH | Per-entry phase kind, 1 = dynamic |
| cfg_len | input | NPH*LEN_W | Per-entry length in units, 0 ends the table |
| cfg_own | input | NPH*NODE_W | Per-entry owner node of a static slot |
| st_ready | input | 1 | A static frame is waiting for this node's slot |
| dq_push | input | 1 | Push a dynamic message into the queue |
| dq_prio | input | PRIO_W | Priority of the pushed message |
| dq_len | input | LEN_W | Length of the pushed message in units |
| peer_req | input | 1 | Some other node is offering a dynamic frame |
| peer_prio | input | PRIO_W | Highest priority among other nodes' offers |
| bus_busy | input | 1 | Another node is driving the bus |
| cyc_pos | output | CYC_W | Position within the bus cycle |
| bus_req | output | 1 | This node offers a dynamic frame this unit |
| req_prio | output | PRIO_W | Priority of the offered frame, 0 when none |
| tx_active | output | 1 | This node is driving a frame |
| tx_start | output | 1 | First unit of a frame |
| tx_done | output | 1 | Last unit of a frame |
| tx_dyn | output | 1 | Current frame is dynamic (0 = static) |

## Verification
The bench builds the block with its default parameters: a cycle of 40 units, an 8-entry table, an 8-deep queue, and NODE_ID 2. The table it drives holds two owned static slots, one foreign slot and two dynamic phases of 10 and 6 units, and it ends with a zero-length entry that leaves units 27 to 39 idle. With this layout, frame lengths of 2 to 9 units reach the exact-fit boundary at the end of the first dynamic phase. They also reach the spill of a non-fitting message into the second phase, the wait across the idle tail into the next cycle, and a message too long for either phase.

// File: rtl/mb_pkg.sv
package mb_pkg;
    typedef enum logic [1:0] {
        PK_IDLE   = 2'd0,
        PK_STATIC = 2'd1,
        PK_DYN    = 2'd2
    } ph_kind_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_TX_ST  = 2'd1,
        S_TX_DYN = 2'd2
    } tx_state_t;
endpackage

// File: rtl/mb_phase_seq.sv
module mb_phase_seq
    import mb_pkg::*;
#(
    parameter int NPH     = 8,
    parameter int LEN_W   = 6,
    parameter int NODE_W  = 3,
    parameter int CYC_LEN = 40,
    localparam int CYC_W  = $clog2(CYC_LEN),
    localparam int IDX_W  = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPH-1:0]          cfg_dyn,
    input  logic [NPH*LEN_W-1:0]    cfg_len,
    input  logic [NPH*NODE_W-1:0]   cfg_own,
    output logic [CYC_W-1:0]        cyc_pos,
    output ph_kind_t                ph_kind,
    output logic                    ph_first,
    output logic [LEN_W-1:0]        ph_left,
    output logic [NODE_W-1:0]       ph_own
);
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] cnt_q;
    logic             done_q;
    logic [LEN_W-1:0] cur_len;
    logic             active;

    always_comb begin
        cur_len  = cfg_len[idx_q*LEN_W +: LEN_W];
        ph_own   = cfg_own[idx_q*NODE_W +: NODE_W];
        active   = !done_q && (cur_len != '0);
        ph_first = active && (cnt_q == '0);
        ph_left  = active ? (cur_len - cnt_q) : '0;
        if (!active)
            ph_kind = PK_IDLE;
        else if (cfg_dyn[idx_q])
            ph_kind = PK_DYN;
        else
            ph_kind = PK_STATIC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_pos <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else if (cyc_pos == CYC_W'(CYC_LEN - 1)) begin
            cyc_pos <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            cyc_pos <= cyc_pos + 1'b1;
            if (active) begin
                if (cnt_q == cur_len - LEN_W'(1)) begin
                    cnt_q <= '0;
                    if (idx_q == IDX_W'(NPH - 1))
                        done_q <= 1'b1;
                    else
                        idx_q <= idx_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mb_dyn_queue.sv
module mb_dyn_queue #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 4,
    parameter int LEN_W  = 6,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [LEN_W-1:0]  push_len,
    input  logic              pop,
    output logic              has_msg,
    output logic [PRIO_W-1:0] top_prio,
    output logic [LEN_W-1:0]  top_len
);
    logic [DEPTH-1:0]  vld;
    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic [LEN_W-1:0]  len_q  [DEPTH];
    logic [IW-1:0]     best_idx;
    logic [IW-1:0]     free_idx;
    logic              full;
    logic              push_ok;

    always_comb begin
        best_idx = '0;
        has_msg  = 1'b0;
        top_prio = '0;
        free_idx = '0;
        full     = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && (!has_msg || prio_q[i] > top_prio)) begin
                best_idx = IW'(i);
                top_prio = prio_q[i];
                has_msg  = 1'b1;
            end
            if (!vld[i] && full) begin
                free_idx = IW'(i);
                full     = 1'b0;
            end
        end
        top_len = has_msg ? len_q[best_idx] : '0;
        push_ok = push && !full && (push_len != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (pop && has_msg)
                vld[best_idx] <= 1'b0;
            if (push_ok) begin
                vld[free_idx]    <= 1'b1;
                prio_q[free_idx] <= push_prio;
                len_q[free_idx]  <= push_len;
            end
        end
    end
endmodule

// File: rtl/mb_tx_fsm.sv
module mb_tx_fsm
    import mb_pkg::*;
#(
    parameter int LEN_W   = 6,
    parameter int PRIO_W  = 4,
    parameter int NODE_W  = 3,
    parameter int NODE_ID = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ph_kind_t          ph_kind,
    input  logic              ph_first,
    input  logic [LEN_W-1:0]  ph_left,
    input  logic [NODE_W-1:0] ph_own,
    input  logic              st_ready,
    input  logic              q_has,
    input  logic [PRIO_W-1:0] q_prio,
    input  logic [LEN_W-1:0]  q_len,
    input  logic              peer_req,
    input  logic [PRIO_W-1:0] peer_prio,
    input  logic              bus_busy,
    output logic              bus_req,
    output logic              pop,
    output logic              tx_active,
    output logic              tx_start,
    output logic              tx_done,
    output logic              tx_dyn
);
    tx_state_t        state;
    logic [LEN_W-1:0] cnt_q;
    logic             first_q;
    logic             st_go;
    logic             dyn_cand;
    logic             dyn_win;

    always_comb begin
        st_go    = (state == S_IDLE) && (ph_kind == PK_STATIC) && ph_first &&
                   (ph_own == NODE_W'(NODE_ID)) && st_ready &&
                   (ph_left >= LEN_W'(2));
        dyn_cand = (state == S_IDLE) && (ph_kind == PK_DYN) && !bus_busy &&
                   q_has && (q_len != '0) && (q_len < ph_left);
        dyn_win  = dyn_cand && (!peer_req || (q_prio > peer_prio));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (st_go) begin
                        state   <= S_TX_ST;
                        cnt_q   <= ph_left - LEN_W'(1);
                        first_q <= 1'b1;
                    end else if (dyn_win) begin
                        state   <= S_TX_DYN;
                        cnt_q   <= q_len;
                        first_q <= 1'b1;
                    end
                end
                S_TX_ST, S_TX_DYN: begin
                    first_q <= 1'b0;
                    cnt_q   <= cnt_q - LEN_W'(1);
                    if (cnt_q == LEN_W'(1))
                        state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_active = (state != S_IDLE);
        tx_dyn    = (state == S_TX_DYN);
        tx_start  = tx_active && first_q;
        tx_done   = tx_active && (cnt_q == LEN_W'(1));
        bus_req   = dyn_cand;
        pop       = dyn_win;
    end
endmodule

// File: rtl/mixbus_ctrl.sv
module mixbus_ctrl
    import mb_pkg::*;
#(
    parameter int NPH     = 8,
    parameter int LEN_W   = 6,
    parameter int NODE_W  = 3,
    parameter int PRIO_W  = 4,
    parameter int QDEPTH  = 8,
    parameter int CYC_LEN = 40,
    parameter int NODE_ID = 2,
    localparam int CYC_W  = $clog2(CYC_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPH-1:0]        cfg_dyn,
    input  logic [NPH*LEN_W-1:0]  cfg_len,
    input  logic [NPH*NODE_W-1:0] cfg_own,
    input  logic                  st_ready,
    input  logic                  dq_push,
    input  logic [PRIO_W-1:0]     dq_prio,
    input  logic [LEN_W-1:0]      dq_len,
    input  logic                  peer_req,
    input  logic [PRIO_W-1:0]     peer_prio,
    input  logic                  bus_busy,
    output logic [CYC_W-1:0]      cyc_pos,
    output logic                  bus_req,
    output logic [PRIO_W-1:0]     req_prio,
    output logic                  tx_active,
    output logic                  tx_start,
    output logic                  tx_done,
    output logic                  tx_dyn
);
    ph_kind_t          ph_kind;
    logic              ph_first;
    logic [LEN_W-1:0]  ph_left;
    logic [NODE_W-1:0] ph_own;
    logic              q_has;
    logic [PRIO_W-1:0] q_prio;
    logic [LEN_W-1:0]  q_len;
    logic              q_pop;

    mb_phase_seq #(
        .NPH(NPH), .LEN_W(LEN_W), .NODE_W(NODE_W), .CYC_LEN(CYC_LEN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_dyn(cfg_dyn), .cfg_len(cfg_len), .cfg_own(cfg_own),
        .cyc_pos(cyc_pos), .ph_kind(ph_kind), .ph_first(ph_first),
        .ph_left(ph_left), .ph_own(ph_own)
    );

    mb_dyn_queue #(
        .DEPTH(QDEPTH), .PRIO_W(PRIO_W), .LEN_W(LEN_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(dq_push), .push_prio(dq_prio), .push_len(dq_len),
        .pop(q_pop),
        .has_msg(q_has), .top_prio(q_prio), .top_len(q_len)
    );

    mb_tx_fsm #(
        .LEN_W(LEN_W), .PRIO_W(PRIO_W), .NODE_W(NODE_W), .NODE_ID(NODE_ID)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ph_kind(ph_kind), .ph_first(ph_first), .ph_left(ph_left), .ph_own(ph_own),
        .st_ready(st_ready),
        .q_has(q_has), .q_prio(q_prio), .q_len(q_len),
        .peer_req(peer_req), .peer_prio(peer_prio), .bus_busy(bus_busy),
        .bus_req(bus_req), .pop(q_pop),
        .tx_active(tx_active), .tx_start(tx_start), .tx_done(tx_done), .tx_dyn(tx_dyn)
    );

    assign req_prio = bus_req ? q_prio : '0;
endmodule

// File: rtl/mixbus_ctrl_chk.sv
module mixbus_ctrl_chk
    import mb_pkg::*;
#(
    parameter int CYC_LEN = 40,
    parameter int CYC_W   = 6,
    parameter int NODE_W  = 3,
    parameter int PRIO_W  = 4,
    parameter int NODE_ID = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CYC_W-1:0]  cyc_pos,
    input ph_kind_t          ph_kind,
    input logic [NODE_W-1:0] ph_own,
    input logic              bus_req,
    input logic [PRIO_W-1:0] req_prio,
    input logic              peer_req,
    input logic [PRIO_W-1:0] peer_prio,
    input logic              tx_active,
    input logic              tx_start,
    input logic              tx_done,
    input logic              tx_dyn
);
    AST_CYC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_pos == CYC_W'(CYC_LEN - 1)) |=> (cyc_pos == '0)); // R1
    AST_IDLE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_kind == PK_IDLE) |-> !bus_req); // R2
    AST_STATIC_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !tx_dyn) |-> (ph_kind == PK_STATIC && ph_own == NODE_W'(NODE_ID))); // R4
    AST_DYN_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && tx_dyn) |-> (ph_kind == PK_DYN)); // R6
    AST_LOST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && peer_req && (peer_prio > req_prio)) |=> !tx_active); // R7
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(!tx_active)); // R8
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !tx_done) |=> (tx_active && $stable(tx_dyn) && !tx_start)); // R8
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_active); // R8
endmodule

bind mixbus_ctrl mixbus_ctrl_chk #(
    .CYC_LEN(CYC_LEN), .CYC_W(CYC_W), .NODE_W(NODE_W), .PRIO_W(PRIO_W), .NODE_ID(NODE_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_pos(cyc_pos), .ph_kind(ph_kind), .ph_own(ph_own),
    .bus_req(bus_req), .req_prio(req_prio), .peer_req(peer_req), .peer_prio(peer_prio),
    .tx_active(tx_active), .tx_start(tx_start), .tx_done(tx_done), .tx_dyn(tx_dyn)
);

// File: tb/mixbus_ctrl_test.sv
module mixbus_ctrl_test;
    localparam int NPH = 8, LEN_W = 6, NODE_W = 3, PRIO_W = 4, CYC_LEN = 40;
    localparam int CYC_W = $clog2(CYC_LEN);

    // rows: prio A, len A, prio B, len B (0 = none), expected start of higher, of lower (-1 none)
    localparam int NROW = 6;
    localparam int VEC [NROW][6] = '{
        '{9, 3, 0, 0,  9, -1},
        '{9, 9, 0, 0,  9, -1},
        '{9, 9, 4, 5,  9, 22},
        '{9, 6, 4, 2,  9, 16},
        '{9, 6, 4, 3,  9, 22},
        '{3, 4, 12, 4, 9, 14}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [NPH-1:0]        cfg_dyn;
    logic [NPH*LEN_W-1:0]  cfg_len;
    logic [NPH*NODE_W-1:0] cfg_own;
    logic st_ready, dq_push, peer_req, bus_busy;
    logic [PRIO_W-1:0] dq_prio, peer_prio, req_prio;
    logic [LEN_W-1:0]  dq_len;
    logic [CYC_W-1:0]  cyc_pos;
    logic bus_req, tx_active, tx_start, tx_done, tx_dyn;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mixbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_dyn(cfg_dyn), .cfg_len(cfg_len), .cfg_own(cfg_own),
        .st_ready(st_ready), .dq_push(dq_push), .dq_prio(dq_prio), .dq_len(dq_len),
        .peer_req(peer_req), .peer_prio(peer_prio), .bus_busy(bus_busy),
        .cyc_pos(cyc_pos), .bus_req(bus_req), .req_prio(req_prio),
        .tx_active(tx_active), .tx_start(tx_start), .tx_done(tx_done), .tx_dyn(tx_dyn)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic to_pos(input int p);
        @(negedge clk);
        while (int'(cyc_pos) != p) @(negedge clk);
    endtask

    task automatic push(input int p, input int l);
        dq_push = 1'b1;
        dq_prio = PRIO_W'(p);
        dq_len  = LEN_W'(l);
    endtask

    // observe until cyc_pos reaches the last unit of the cycle
    task automatic watch(output int s1, output int d1, output int s2, output int d2,
                         output int ns, output int nd, output int breq, output int sdyn);
        s1 = -1; d1 = -1; s2 = -1; d2 = -1; ns = 0; nd = 0; breq = 0; sdyn = 0;
        forever begin
            if (bus_req) breq++;
            if (tx_start) begin
                if (ns == 0) s1 = int'(cyc_pos); else s2 = int'(cyc_pos);
                if (tx_dyn) sdyn++;
                ns++;
            end
            if (tx_done) begin
                if (nd == 0) d1 = int'(cyc_pos); else d2 = int'(cyc_pos);
                nd++;
            end
            if (int'(cyc_pos) == CYC_LEN - 1) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int s1, d1, s2, d2, ns, nd, br, sd;
        int hp, hl, lp, ll;
        bit wrapped;
        cfg_dyn = 8'b0001_0100;
        cfg_len = '0;
        cfg_own = '0;
        cfg_len[0*LEN_W +: LEN_W] = 6'd4;  cfg_own[0*NODE_W +: NODE_W] = 3'd2;
        cfg_len[1*LEN_W +: LEN_W] = 6'd4;  cfg_own[1*NODE_W +: NODE_W] = 3'd5;
        cfg_len[2*LEN_W +: LEN_W] = 6'd10;
        cfg_len[3*LEN_W +: LEN_W] = 6'd3;  cfg_own[3*NODE_W +: NODE_W] = 3'd2;
        cfg_len[4*LEN_W +: LEN_W] = 6'd6;
        st_ready = 0; dq_push = 0; dq_prio = '0; dq_len = '0;
        peer_req = 0; peer_prio = '0; bus_busy = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cyc_pos == 0, "R9 reset cyc_pos", int'(cyc_pos), 0);
        chk(!tx_active && !tx_start && !tx_done, "R9 reset tx idle", int'(tx_active), 0);
        chk(!bus_req, "R9 reset bus_req", int'(bus_req), 0);
        rst_n = 1;

        // R1 wrap
        to_pos(CYC_LEN - 1);
        @(negedge clk);
        chk(cyc_pos == 0, "R1 wrap to zero", int'(cyc_pos), 0);

        // R5 R6 vector table
        for (int r = 0; r < NROW; r++) begin
            if (VEC[r][2] == 0 || VEC[r][0] > VEC[r][2]) begin
                hp = VEC[r][0]; hl = VEC[r][1]; lp = VEC[r][2]; ll = VEC[r][3];
            end else begin
                hp = VEC[r][2]; hl = VEC[r][3]; lp = VEC[r][0]; ll = VEC[r][1];
            end
            to_pos(0);
            push(VEC[r][0], VEC[r][1]);
            @(negedge clk);
            if (VEC[r][3] != 0) push(VEC[r][2], VEC[r][3]); else dq_push = 1'b0;
            @(negedge clk);
            dq_push = 1'b0;
            watch(s1, d1, s2, d2, ns, nd, br, sd);
            chk(s1 == VEC[r][4], $sformatf("R5 R6 row%0d first start", r), s1, VEC[r][4]);
            chk(d1 == VEC[r][4] + hl - 1, $sformatf("R6 R8 row%0d first done", r), d1, VEC[r][4] + hl - 1);
            chk(sd == ns, $sformatf("R5 row%0d frames dynamic", r), sd, ns);
            if (VEC[r][5] >= 0) begin
                chk(s2 == VEC[r][5], $sformatf("R5 R6 row%0d second start", r), s2, VEC[r][5]);
                chk(d2 == VEC[r][5] + ll - 1, $sformatf("R6 R8 row%0d second done", r), d2, VEC[r][5] + ll - 1);
            end else begin
                chk(ns == 1, $sformatf("R6 row%0d single frame", r), ns, 1);
            end
        end

        // R3 R4 static slots: owned slots 0 and 3, foreign slot 1
        to_pos(0);
        st_ready = 1'b1;
        watch(s1, d1, s2, d2, ns, nd, br, sd);
        st_ready = 1'b0;
        chk(s1 == 1, "R3 static start slot0", s1, 1);
        chk(d1 == 3, "R3 static done slot0", d1, 3);
        chk(s2 == 19, "R3 R4 static start slot3, none in foreign slot", s2, 19);
        chk(d2 == 20, "R3 static done slot3", d2, 20);
        chk(sd == 0, "R3 static frames not dynamic", sd, 0);

        // R4 st_ready low in owned slot: no frame
        to_pos(0);
        watch(s1, d1, s2, d2, ns, nd, br, sd);
        chk(ns == 0, "R4 no static frame without ready", ns, 0);

        // R7 lost arbitration then bus busy
        to_pos(0);
        push(5, 3);
        peer_req = 1'b1; peer_prio = 4'd7;
        @(negedge clk);
        dq_push = 1'b0;
        to_pos(8);
        chk(bus_req == 1'b1, "R5 offer at phase start", int'(bus_req), 1);
        chk(req_prio == 4'd5, "R5 offered priority", int'(req_prio), 5);
        @(negedge clk);
        chk(!tx_active, "R7 lost offer starts nothing", int'(tx_active), 0);
        peer_req = 1'b0; bus_busy = 1'b1;
        to_pos(12);
        bus_busy = 1'b0;
        watch(s1, d1, s2, d2, ns, nd, br, sd);
        chk(s1 == 13, "R7 retry after bus free", s1, 13);
        chk(d1 == 15, "R7 retried frame done", d1, 15);

        // R7 win against lower peer
        to_pos(0);
        push(5, 3);
        peer_req = 1'b1; peer_prio = 4'd2;
        @(negedge clk);
        dq_push = 1'b0;
        watch(s1, d1, s2, d2, ns, nd, br, sd);
        peer_req = 1'b0;
        chk(s1 == 9, "R7 win over lower peer", s1, 9);

        // R2 push during idle tail: waits until next cycle's dynamic phase
        to_pos(27);
        push(6, 5);
        @(negedge clk);
        dq_push = 1'b0;
        wrapped = 1'b0;
        s1 = -1;
        for (int k = 0; k < 60; k++) begin
            if (cyc_pos == 0) wrapped = 1'b1;
            if (tx_start) begin
                s1 = wrapped ? int'(cyc_pos) : 100 + int'(cyc_pos);
                break;
            end
            @(negedge clk);
        end
        chk(s1 == 9, "R2 idle tail defers to next cycle", s1, 9);

        // R6 too long for any phase: never offered
        to_pos(0);
        push(1, 12);
        @(negedge clk);
        dq_push = 1'b0;
        watch(s1, d1, s2, d2, ns, nd, br, sd);
        chk(ns == 0, "R6 oversize never starts", ns, 0);
        chk(br == 0, "R6 oversize never offered", br, 0);

        // R9 reset empties queue
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(!tx_active && !bus_req, "R9 reset idle", int'(tx_active), 0);
        rst_n = 1;
        push(8, 3);
        @(negedge clk);
        dq_push = 1'b0;
        watch(s1, d1, s2, d2, ns, nd, br, sd);
        chk(ns == 1 && s1 == 9, "R9 only new message after reset", s1, 9);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule